// File: doc/BRIEF.md
# Indirect Transfer Buffer Controller

This block moves serial-flash data between a host-visible data window and one on-chip word buffer, so that a host can stream large transfers through a single address. The word buffer is split in two by a programmable boundary. The lower part buffers words arriving from the flash side for the host to collect. The upper part buffers words the host deposits for the flash side to take. The flash side is a pair of valid/ready word streams, one for each direction.

Software sets a byte count for a direction and writes its start bit. The engine then accepts or offers just enough words to cover that count. It raises a done flag once the transfer is complete. Fill levels can be read back. Sticky interrupt status bits record watermark crossings, a stalled full read area, a write-side starvation and completion, and a mask routes them to one interrupt line. A cancel aborts a direction and empties its area.

Top module: `ixb_engine`

Register offsets (32-bit host data, byte addresses): 0x00 config (bit 0 enable, bit 1 idle, read-only), 0x04 boundary (words given to the read area), 0x08 read control, 0x0C read byte count, 0x10 write control, 0x14 write byte count, 0x18 read watermark (bytes), 0x1C write watermark (bytes), 0x20 interrupt status (write 1 to clear), 0x24 interrupt mask, 0x28 read-area level (words), 0x2C write-area level (words). The data window sits at 0x80. In both control registers, bit 0 is start, bit 1 is cancel, and bit 2 is done (write 1 to clear).

## Requirements
- R1: After reset, config reads 2 (idle set, enable clear), the boundary reads DEPTH/2, both levels read 0, the mask is 0 and irq is low.
- R2: The read area holds exactly boundary words. When it is full, fl_rd_ready stays low and a word still offered sets status bit 12. The read level register reports the stored word count.
- R3: After a read start with byte count N, the engine accepts exactly ceil(N/4) words from the flash side. Host reads of 0x80 return them in arrival order. Once all have been collected, the read done bit (control bit 2) and status bit 2 are set.
- R4: After a write start with byte count N, words written by the host to 0x80 are offered on fl_wr_data in order. Exactly ceil(N/4) words are handed over, then write done and status bit 2 are set.
- R5: Writing 1 to a control register's bit 2 clears that done bit. Writing ones to interrupt status clears those bits.
- R6: A cancel (control bit 1) empties that direction's area, ends the transfer, and leaves done clear.
- R7: Status bit 1 is set when the flash side signals fl_wr_ready while a write is owed bytes and the write area is empty. It stays clear in a transfer that never starves.
- R8: Status bit 6 is set when the read level in bytes rises to at least the read watermark during a read. It is also set when the write level in bytes falls to or below the write watermark during a write.
- R9: irq is high exactly when a status bit that is also set in the mask is set. With a zero mask, irq stays low.
- R10: With enable clear, start writes are ignored and neither stream handshakes.
- R11: The config idle bit is low while either direction is active and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hreq | input | 1 | Host access strobe, one cycle per access |
| hwe | input | 1 | Host access is a write |
| haddr | input | AW | Host byte address |
| hwdata | input | DW | Host write data |
| hrdata | output | DW | Host read data, valid in the cycle of the access |
| irq | output | 1 | Masked interrupt line |
| fl_rd_valid | input | 1 | Flash side offers a word |
| fl_rd_ready | output | 1 | Engine accepts the offered word |
| fl_rd_data | input | DW | Word from flash side |
| fl_wr_valid | output | 1 | Engine offers a word to the flash side |
| fl_wr_ready | input | 1 | Flash side takes the word or requests data |
| fl_wr_data | output | DW | Word to flash side |

## Verification
A corrupted area pointer or level shows up within one access: the level register reads a wrong count, or the words read back through the window come out duplicated, missing or reordered. A byte counter that is off by one is visible at fl_rd_ready or fl_wr_valid in the cycle after the last expected word, and the done bit then appears a cycle early or never. Flag logic that is wrong shows up as a status bit or irq that differs in the cycle after the triggering handshake.

// File: rtl/ixb_pkg.sv
package ixb_pkg;
    localparam logic [7:0] A_CFG    = 8'h00;
    localparam logic [7:0] A_SPLIT  = 8'h04;
    localparam logic [7:0] A_RCTL   = 8'h08;
    localparam logic [7:0] A_RBYTES = 8'h0C;
    localparam logic [7:0] A_WCTL   = 8'h10;
    localparam logic [7:0] A_WBYTES = 8'h14;
    localparam logic [7:0] A_RWM    = 8'h18;
    localparam logic [7:0] A_WWM    = 8'h1C;
    localparam logic [7:0] A_ISTAT  = 8'h20;
    localparam logic [7:0] A_IMASK  = 8'h24;
    localparam logic [7:0] A_RLVL   = 8'h28;
    localparam logic [7:0] A_WLVL   = 8'h2C;

    localparam int IW        = 13;
    localparam int IRQ_UNDER = 1;
    localparam int IRQ_DONE  = 2;
    localparam int IRQ_WMARK = 6;
    localparam int IRQ_RFULL = 12;

    localparam int C_START  = 0;
    localparam int C_CANCEL = 1;
    localparam int C_DONE   = 2;
endpackage

// File: rtl/ixb_sram.sv
module ixb_sram #(
    parameter int DEPTH = 16,
    parameter int DW    = 32,
    localparam int PW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we0,
    input  logic [PW-1:0] a0,
    input  logic [DW-1:0] d0,
    input  logic          we1,
    input  logic [PW-1:0] a1,
    input  logic [DW-1:0] d1,
    input  logic [PW-1:0] ra0,
    output logic [DW-1:0] q0,
    input  logic [PW-1:0] ra1,
    output logic [DW-1:0] q1
);
    logic [DW-1:0] mem [DEPTH];

    // The two areas never overlap, so the two write ports never collide.
    always_ff @(posedge clk) begin
        if (we0) mem[a0] <= d0;
        if (we1) mem[a1] <= d1;
    end

    assign q0 = mem[ra0];
    assign q1 = mem[ra1];
endmodule

// File: rtl/ixb_part.sv
module ixb_part #(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [LW-1:0] size,
    output logic [LW-1:0] level,
    output logic [PW-1:0] wptr,
    output logic [PW-1:0] rptr,
    output logic          full,
    output logic          empty
);
    logic [PW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
    logic [LW-1:0] lvl_q, lvl_d;
    logic          do_push, do_pop;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p, input logic [LW-1:0] sz);
        return ({1'b0, p} + LW'(1) == sz) ? '0 : p + PW'(1);
    endfunction

    assign full    = (lvl_q == size);
    assign empty   = (lvl_q == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_comb begin
        wptr_d = wptr_q;
        rptr_d = rptr_q;
        lvl_d  = lvl_q;
        if (flush) begin
            wptr_d = '0;
            rptr_d = '0;
            lvl_d  = '0;
        end else begin
            if (do_push) wptr_d = bump(wptr_q, size);
            if (do_pop)  rptr_d = bump(rptr_q, size);
            lvl_d = lvl_q + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            lvl_q  <= '0;
        end else begin
            wptr_q <= wptr_d;
            rptr_q <= rptr_d;
            lvl_q  <= lvl_d;
        end
    end

    assign level = lvl_q;
    assign wptr  = wptr_q;
    assign rptr  = rptr_q;
endmodule

// File: rtl/ixb_engine.sv
module ixb_engine
    import ixb_pkg::*;
#(
    parameter int          DEPTH = 16,
    parameter int          DW    = 32,
    parameter int          CW    = 16,
    parameter int          AW    = 8,
    parameter logic [AW-1:0] TRIG = 8'h80
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          hreq,
    input  logic          hwe,
    input  logic [AW-1:0] haddr,
    input  logic [DW-1:0] hwdata,
    output logic [DW-1:0] hrdata,
    output logic          irq,
    input  logic          fl_rd_valid,
    output logic          fl_rd_ready,
    input  logic [DW-1:0] fl_rd_data,
    output logic          fl_wr_valid,
    input  logic          fl_wr_ready,
    output logic [DW-1:0] fl_wr_data
);
    localparam int PW  = $clog2(DEPTH);
    localparam int LW  = PW + 1;
    localparam int BPW = DW / 8;

    typedef struct packed {
        logic          en;
        logic [PW-1:0] split;
        logic          rd_act, rd_done, wr_act, wr_done;
        logic [CW-1:0] rd_cnt, rd_left, wr_cnt, wr_left, rd_wm, wr_wm;
        logic [IW-1:0] stat, mask;
        logic          rd_hit, wr_hit;
    } st_t;

    st_t q, d;

    logic [LW-1:0] rsize, wsize, rd_lvl, wr_lvl;
    logic [PW-1:0] rd_wp, rd_rp, wr_wp, wr_rp;
    logic          rd_full, rd_empty, wr_full, wr_empty;
    logic          rd_push, rd_pop, wr_push, wr_pop, rd_flush, wr_flush;
    logic          hw_en, hr_en, win, rd_hit_now, wr_hit_now;
    logic [DW-1:0] rd_head;
    logic          unused_bits;

    function automatic logic [CW-1:0] take(input logic [CW-1:0] left);
        return (left >= CW'(BPW)) ? CW'(BPW) : left;
    endfunction

    assign unused_bits = ^hwdata[DW-1:CW];
    assign rsize = {1'b0, q.split};
    assign wsize = LW'(DEPTH) - rsize;
    assign hw_en = hreq && hwe;
    assign hr_en = hreq && !hwe;
    assign win   = (haddr == TRIG);

    assign fl_rd_ready = q.en && q.rd_act && (q.rd_left != '0) && !rd_full;
    assign fl_wr_valid = q.en && q.wr_act && (q.wr_left != '0) && !wr_empty;
    assign rd_push = fl_rd_valid && fl_rd_ready;
    assign rd_pop  = hr_en && win && !rd_empty;
    assign wr_pop  = fl_wr_valid && fl_wr_ready;
    assign wr_push = hw_en && win && q.wr_act && !wr_full;
    assign rd_hit_now = (CW'(rd_lvl) * CW'(BPW)) >= q.rd_wm;
    assign wr_hit_now = q.wr_act && ((CW'(wr_lvl) * CW'(BPW)) <= q.wr_wm);
    assign irq = |(q.stat & q.mask);

    ixb_part #(.DEPTH(DEPTH)) u_rpart (
        .clk(clk), .rst_n(rst_n), .flush(rd_flush), .push(rd_push), .pop(rd_pop),
        .size(rsize), .level(rd_lvl), .wptr(rd_wp), .rptr(rd_rp),
        .full(rd_full), .empty(rd_empty));

    ixb_part #(.DEPTH(DEPTH)) u_wpart (
        .clk(clk), .rst_n(rst_n), .flush(wr_flush), .push(wr_push), .pop(wr_pop),
        .size(wsize), .level(wr_lvl), .wptr(wr_wp), .rptr(wr_rp),
        .full(wr_full), .empty(wr_empty));

    ixb_sram #(.DEPTH(DEPTH), .DW(DW)) u_sram (
        .clk(clk),
        .we0(rd_push), .a0(rd_wp), .d0(fl_rd_data),
        .we1(wr_push), .a1(q.split + wr_wp), .d1(hwdata),
        .ra0(rd_rp), .q0(rd_head),
        .ra1(q.split + wr_rp), .q1(fl_wr_data));

    always_comb begin
        d        = q;
        rd_flush = 1'b0;
        wr_flush = 1'b0;
        d.rd_hit = rd_hit_now;
        d.wr_hit = wr_hit_now;
        if (rd_hit_now && !q.rd_hit && q.rd_act) d.stat[IRQ_WMARK] = 1'b1;
        if (wr_hit_now && !q.wr_hit)             d.stat[IRQ_WMARK] = 1'b1;
        if (rd_push) d.rd_left = q.rd_left - take(q.rd_left);
        if (wr_pop)  d.wr_left = q.wr_left - take(q.wr_left);
        if (q.en && q.rd_act && (q.rd_left != '0) && rd_full && fl_rd_valid)
            d.stat[IRQ_RFULL] = 1'b1;
        if (q.en && q.wr_act && (q.wr_left != '0) && wr_empty && fl_wr_ready)
            d.stat[IRQ_UNDER] = 1'b1;
        if (q.rd_act && (q.rd_left == '0) && rd_empty) begin
            d.rd_act = 1'b0; d.rd_done = 1'b1; d.stat[IRQ_DONE] = 1'b1;
        end
        if (q.wr_act && (q.wr_left == '0)) begin
            d.wr_act = 1'b0; d.wr_done = 1'b1; d.stat[IRQ_DONE] = 1'b1;
        end
        if (hw_en) begin
            unique case (haddr)
                A_CFG:   d.en = hwdata[0];
                A_SPLIT: if (!q.rd_act && !q.wr_act) begin
                    d.split = hwdata[PW-1:0]; rd_flush = 1'b1; wr_flush = 1'b1;
                end
                A_RCTL: begin
                    if (hwdata[C_DONE]) d.rd_done = 1'b0;
                    if (hwdata[C_CANCEL]) begin
                        d.rd_act = 1'b0; d.rd_left = '0; rd_flush = 1'b1;
                    end else if (hwdata[C_START] && q.en && !q.rd_act) begin
                        d.rd_act = 1'b1; d.rd_left = q.rd_cnt; d.rd_done = 1'b0; rd_flush = 1'b1;
                    end
                end
                A_WCTL: begin
                    if (hwdata[C_DONE]) d.wr_done = 1'b0;
                    if (hwdata[C_CANCEL]) begin
                        d.wr_act = 1'b0; d.wr_left = '0; wr_flush = 1'b1;
                    end else if (hwdata[C_START] && q.en && !q.wr_act) begin
                        d.wr_act = 1'b1; d.wr_left = q.wr_cnt; d.wr_done = 1'b0; wr_flush = 1'b1;
                    end
                end
                A_RBYTES: d.rd_cnt = hwdata[CW-1:0];
                A_WBYTES: d.wr_cnt = hwdata[CW-1:0];
                A_RWM:    d.rd_wm  = hwdata[CW-1:0];
                A_WWM:    d.wr_wm  = hwdata[CW-1:0];
                A_ISTAT:  d.stat   = d.stat & ~hwdata[IW-1:0];
                A_IMASK:  d.mask   = hwdata[IW-1:0];
                default: ;
            endcase
        end
    end

    always_comb begin
        hrdata = '0;
        if (hr_en) begin
            if (win) hrdata = rd_empty ? '0 : rd_head;
            else begin
                unique case (haddr)
                    A_CFG:    hrdata = DW'({!q.rd_act && !q.wr_act, q.en});
                    A_SPLIT:  hrdata = DW'(q.split);
                    A_RCTL:   hrdata = DW'({q.rd_act, q.rd_done, 2'b00});
                    A_WCTL:   hrdata = DW'({q.wr_act, q.wr_done, 2'b00});
                    A_RBYTES: hrdata = DW'(q.rd_cnt);
                    A_WBYTES: hrdata = DW'(q.wr_cnt);
                    A_RWM:    hrdata = DW'(q.rd_wm);
                    A_WWM:    hrdata = DW'(q.wr_wm);
                    A_ISTAT:  hrdata = DW'(q.stat);
                    A_IMASK:  hrdata = DW'(q.mask);
                    A_RLVL:   hrdata = DW'(rd_lvl);
                    A_WLVL:   hrdata = DW'(wr_lvl);
                    default:  hrdata = '0;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.split <= PW'(DEPTH / 2);
            q.rd_wm <= CW'(DEPTH * BPW / 2);
            q.wr_wm <= CW'(DEPTH * BPW / 8);
        end else begin
            q <= d;
        end
    end

    logic          en_w, rd_act_w, rd_done_w, wr_act_w;
    logic [PW-1:0] split_w;
    logic [IW-1:0] mask_w;
    assign en_w      = q.en;
    assign rd_act_w  = q.rd_act;
    assign rd_done_w = q.rd_done;
    assign wr_act_w  = q.wr_act;
    assign split_w   = q.split;
    assign mask_w    = q.mask;
endmodule

// File: rtl/ixb_chk.sv
module ixb_chk
    import ixb_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = PW + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic [PW-1:0] split,
    input logic [LW-1:0] rd_lvl,
    input logic          rd_act,
    input logic          rd_done,
    input logic          wr_act,
    input logic          fl_rd_valid,
    input logic          fl_rd_ready,
    input logic          fl_wr_valid,
    input logic          irq,
    input logic [IW-1:0] mask
);
    AST_RD_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        rd_lvl <= {1'b0, split}); // R2
    AST_RD_PUSH_STORED: assert property (@(posedge clk) disable iff (!rst_n)
        fl_rd_valid && fl_rd_ready |=> rd_lvl != '0); // R3
    AST_RD_DONE_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_done) |-> $past(rd_act)); // R3
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        mask == '0 |-> !irq); // R9
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> !fl_rd_ready && !fl_wr_valid); // R10
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_act && !wr_act |-> !fl_rd_ready && !fl_wr_valid); // R11
endmodule

bind ixb_engine ixb_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .en(en_w), .split(split_w), .rd_lvl(rd_lvl),
    .rd_act(rd_act_w), .rd_done(rd_done_w), .wr_act(wr_act_w),
    .fl_rd_valid(fl_rd_valid), .fl_rd_ready(fl_rd_ready), .fl_wr_valid(fl_wr_valid),
    .irq(irq), .mask(mask_w));

// File: tb/sim_ixb_engine.sv
module sim_ixb_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        hreq = 1'b0, hwe = 1'b0;
    logic [7:0]  haddr = '0;
    logic [31:0] hwdata = '0, hrdata;
    logic        irq;
    logic        fl_rd_valid = 1'b0, fl_rd_ready;
    logic [31:0] fl_rd_data = '0;
    logic        fl_wr_valid, fl_wr_ready = 1'b0;
    logic [31:0] fl_wr_data;
    int          n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    ixb_engine u0 (
        .clk(clk), .rst_n(rst_n), .hreq(hreq), .hwe(hwe), .haddr(haddr),
        .hwdata(hwdata), .hrdata(hrdata), .irq(irq),
        .fl_rd_valid(fl_rd_valid), .fl_rd_ready(fl_rd_ready), .fl_rd_data(fl_rd_data),
        .fl_wr_valid(fl_wr_valid), .fl_wr_ready(fl_wr_ready), .fl_wr_data(fl_wr_data));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic hw(input logic [7:0] a, input logic [31:0] v);
        @(negedge clk); hreq = 1'b1; hwe = 1'b1; haddr = a; hwdata = v;
        @(negedge clk); hreq = 1'b0; hwe = 1'b0;
    endtask

    task automatic hr(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); hreq = 1'b1; hwe = 1'b0; haddr = a;
        #1 v = hrdata;
        @(negedge clk); hreq = 1'b0;
    endtask

    task automatic flash_push(input logic [31:0] w);
        logic done = 1'b0;
        @(negedge clk); fl_rd_valid = 1'b1; fl_rd_data = w;
        for (int i = 0; i < 40 && !done; i++) begin
            #1;
            if (fl_rd_ready) done = 1'b1;
            @(negedge clk);
        end
        fl_rd_valid = 1'b0;
        chk("R3 flash word accepted", 32'(done), 32'd1);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        hr(8'h00, v); chk("R1 config after reset", v, 32'd2);
        hr(8'h04, v); chk("R1 boundary after reset", v, 32'd8);
        hr(8'h28, v); chk("R1 read level after reset", v, 32'd0);
        hr(8'h24, v); chk("R1 mask after reset", v, 32'd0);
        chk("R1 irq after reset", 32'(irq), 32'd0);
    endtask

    task automatic t_disabled();
        logic [31:0] v;
        hw(8'h0C, 32'd8);
        hw(8'h08, 32'd1);
        hr(8'h00, v); chk("R10 start ignored while disabled", v, 32'd2);
        fl_rd_valid = 1'b1; #1;
        chk("R10 no ready while disabled", 32'(fl_rd_ready), 32'd0);
        fl_rd_valid = 1'b0;
        hw(8'h00, 32'd1);
    endtask

    task automatic t_read();
        logic [31:0] v;
        hw(8'h0C, 32'd10);
        hw(8'h08, 32'd1);
        hr(8'h00, v); chk("R11 idle low during read", v, 32'd1);
        flash_push(32'h1111_0001);
        flash_push(32'h1111_0002);
        flash_push(32'h1111_0003);
        fl_rd_valid = 1'b1; #1;
        chk("R3 no fourth word for 10 bytes", 32'(fl_rd_ready), 32'd0);
        fl_rd_valid = 1'b0;
        hr(8'h28, v); chk("R2 read level in words", v, 32'd3);
        hr(8'h80, v); chk("R3 first word", v, 32'h1111_0001);
        hr(8'h80, v); chk("R3 second word", v, 32'h1111_0002);
        hr(8'h80, v); chk("R3 third word", v, 32'h1111_0003);
        hr(8'h08, v); chk("R3 read done bit", v & 32'h4, 32'h4);
        hr(8'h20, v); chk("R3 completion status", v & 32'h4, 32'h4);
        hr(8'h00, v); chk("R11 idle after read", v, 32'd3);
        hw(8'h08, 32'h4);
        hr(8'h08, v); chk("R5 done cleared by write one", v, 32'd0);
        hw(8'h20, 32'h1FFF);
        hr(8'h20, v); chk("R5 status cleared by write ones", v, 32'd0);
    endtask

    task automatic t_full();
        logic [31:0] v;
        hw(8'h0C, 32'd40);
        hw(8'h08, 32'd1);
        for (int i = 0; i < 8; i++) flash_push(32'h2222_0000 + 32'(i));
        @(negedge clk); fl_rd_valid = 1'b1; fl_rd_data = 32'hDEAD_0009; #1;
        chk("R2 stalled when read area full", 32'(fl_rd_ready), 32'd0);
        @(negedge clk); fl_rd_valid = 1'b0;
        hr(8'h20, v); chk("R2 full status bit 12", (v >> 12) & 32'h1, 32'd1);
        hr(8'h28, v); chk("R2 level equals boundary", v, 32'd8);
        hw(8'h08, 32'h2);
        hr(8'h28, v); chk("R6 cancel empties read area", v, 32'd0);
        hr(8'h08, v); chk("R6 cancel leaves done clear", v, 32'd0);
        hr(8'h00, v); chk("R6 idle after cancel", v, 32'd3);
        hw(8'h20, 32'h1FFF);
    endtask

    task automatic t_wmark();
        logic [31:0] v;
        hw(8'h18, 32'd8);
        hw(8'h24, 32'h40);
        hw(8'h0C, 32'd16);
        hw(8'h08, 32'd1);
        flash_push(32'h3333_0001);
        @(negedge clk); #1;
        chk("R8 no watermark below threshold", 32'(irq), 32'd0);
        flash_push(32'h3333_0002);
        @(negedge clk); #1;
        chk("R8 watermark raises irq", 32'(irq), 32'd1);
        hw(8'h24, 32'h0);
        #1 chk("R9 zero mask silences irq", 32'(irq), 32'd0);
        hr(8'h20, v); chk("R9 status kept while masked", (v >> 6) & 32'h1, 32'd1);
        hw(8'h08, 32'h2);
        hw(8'h20, 32'h1FFF);
    endtask

    task automatic t_write();
        logic [31:0] v;
        logic [31:0] exp [2];
        int got = 0;
        exp[0] = 32'hA5A5_0001; exp[1] = 32'hA5A5_0002;
        hw(8'h14, 32'd6);
        hw(8'h10, 32'd1);
        hw(8'h80, exp[0]);
        hw(8'h80, exp[1]);
        hr(8'h2C, v); chk("R4 write level in words", v, 32'd2);
        for (int i = 0; i < 20 && got < 3; i++) begin
            @(negedge clk); fl_wr_ready = 1'b1; #1;
            if (fl_wr_valid) begin
                if (got < 2) chk("R4 word order to flash", fl_wr_data, exp[got]);
                got++;
            end
        end
        @(negedge clk); fl_wr_ready = 1'b0;
        chk("R4 exactly two words handed over", 32'(got), 32'd2);
        hr(8'h10, v); chk("R4 write done bit", v & 32'h4, 32'h4);
        hr(8'h20, v); chk("R4 completion status", v & 32'h4, 32'h4);
        chk("R7 no underflow when never starved", (v >> 1) & 32'h1, 32'd0);
        chk("R8 write watermark at start", (v >> 6) & 32'h1, 32'd1);
        hw(8'h10, 32'h4);
        hw(8'h20, 32'h1FFF);
    endtask

    task automatic t_underflow();
        logic [31:0] v;
        hw(8'h14, 32'd4);
        hw(8'h10, 32'd1);
        @(negedge clk); fl_wr_ready = 1'b1;
        @(negedge clk); fl_wr_ready = 1'b0;
        hr(8'h20, v); chk("R7 underflow on empty write area", (v >> 1) & 32'h1, 32'd1);
        hw(8'h80, 32'hBEEF_0001);
        @(negedge clk); fl_wr_ready = 1'b1; #1;
        chk("R4 single word offered", fl_wr_data, 32'hBEEF_0001);
        @(negedge clk); fl_wr_ready = 1'b0;
        hr(8'h10, v); chk("R4 done after one word", v, 32'h4);
        hr(8'h00, v); chk("R11 idle after write", v, 32'd3);
    endtask

    initial begin
        #(8 * 100000);
        n_bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_disabled();
        t_read();
        t_full();
        t_wmark();
        t_write();
        t_underflow();
        repeat (3) @(negedge clk);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule